// File: doc/BRIEF.md
# Log-Domain Multiply/Divide Unit

This unit multiplies or divides two real numbers kept in logarithmic form. Each operand and the result is a triple: a zero flag, a sign bit and an unsigned code of N = INT_W + FRAC_W bits. The code holds the base-2 logarithm of the magnitude as fixed point, with INT_W integer bits and FRAC_W fractional bits. The integer part is stored with an excess bias of 2^(INT_W-1) - 1, so the code value is (log2|x| + bias) * 2^FRAC_W. The represented value is (1 - zero) * (-1)^sign * 2^(code/2^FRAC_W - bias).

In the log domain a product is a sum and a quotient is a difference. The unit adds or subtracts the two codes and puts the bias back once, so the result stays in biased form. It XORs the signs and resolves zero operands and division by zero through flags. A result code above the top of the range is saturated and flagged. A result code below zero is flushed to zero and flagged. Operands are taken on a valid strobe and the result appears in an output register one clock later.

Top module: `lmd_muldiv`

## Requirements
- R1: With op_div = 0 and both zero flags clear, r_log = a_log + b_log - B, where B = (2^(INT_W-1) - 1) * 2^FRAC_W, as long as that value lies in 0 .. 2^N - 1. In that case r_zero, r_ovf, r_unf and r_dbz are 0.
- R2: With op_div = 1 and both zero flags clear, r_log = a_log - b_log + B, as long as that value lies in 0 .. 2^N - 1. In that case all flags are 0.
- R3: Every result with r_zero = 0 carries r_sign = a_sign XOR b_sign.
- R4: A multiply with a_zero or b_zero set gives r_zero = 1, r_sign = 0, r_log = 0 and no ovf, unf or dbz flag. Every result with r_zero = 1 has r_sign = 0 and r_log = 0.
- R5: A divide with a_zero = 1 and b_zero = 0 gives the zero result (r_zero = 1, r_sign = 0, r_log = 0) with r_dbz = 0.
- R6: A divide with b_zero = 1 raises r_dbz. If a_zero = 0 the result is r_log = 2^N - 1, r_zero = 0 and r_sign = a_sign XOR b_sign. If a_zero = 1 the result is the zero result. In both cases r_ovf = r_unf = 0. A multiply never raises r_dbz.
- R7: When the exact biased result exceeds 2^N - 1, r_log = 2^N - 1, r_ovf = 1 and r_zero = 0. A result of exactly 2^N - 1 does not raise r_ovf.
- R8: When the exact biased result is below 0, the output is the zero result with r_unf = 1. A result of exactly 0 is kept as code 0 with r_zero = 0 and r_unf = 0.
- R9: valid_out is high in exactly the cycle after each cycle in which valid_in is high. While valid_in is low, the result outputs keep their last values.
- R10: During reset, valid_out and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Operands are present this cycle |
| op_div | input | 1 | 0 = multiply, 1 = divide (a / b) |
| a_zero | input | 1 | Operand a is zero |
| a_sign | input | 1 | Sign of operand a (1 = negative) |
| a_log | input | INT_W+FRAC_W | Biased log code of operand a |
| b_zero | input | 1 | Operand b is zero |
| b_sign | input | 1 | Sign of operand b |
| b_log | input | INT_W+FRAC_W | Biased log code of operand b |
| valid_out | output | 1 | Result registered from the previous valid cycle |
| r_zero | output | 1 | Result is zero |
| r_sign | output | 1 | Result sign |
| r_log | output | INT_W+FRAC_W | Biased log code of the result |
| r_ovf | output | 1 | Result saturated at the top code |
| r_unf | output | 1 | Result flushed to zero from below range |
| r_dbz | output | 1 | Divide with a zero divisor |

## Verification
The bench aims directed operands at both ends of the code range: results landing exactly on 2^N - 1 and exactly on 0, and results one step past each end, for both multiply and divide. A design that puts the bias back with the wrong sign, or uses a range test that is off by one, flags or saturates a legal edge value, or wraps an illegal one. Zero operands are crossed with both operations, including a zero divided by zero. A design that lets a zero flag into the arithmetic, or that ranks the zero dividend above the divide-by-zero flag, returns a nonzero code or loses r_dbz. Random operands mixed with near-boundary pairs exercise the sign XOR and the hold of outputs between valid strobes.

// File: rtl/lmd_pkg.sv
package lmd_pkg;

   // operation selected by the mode input
   typedef enum logic {
      LMD_MUL = 1'b0,
      LMD_DIV = 1'b1
   } lmd_op_e;

   // where the unclamped biased code fell relative to the legal range
   typedef enum logic [1:0] {
      LMD_RNG_IN   = 2'd0,
      LMD_RNG_HIGH = 2'd1,
      LMD_RNG_LOW  = 2'd2
   } lmd_rng_e;

endpackage

// File: rtl/lmd_log_adder.sv
// Biased add/subtract of two log codes, with range classification.
module lmd_log_adder #(
   parameter int INT_W  = 8,
   parameter int FRAC_W = 23,
   localparam int N     = INT_W + FRAC_W
) (
   input  lmd_pkg::lmd_op_e op,
   input  logic [N-1:0]     a_log,
   input  logic [N-1:0]     b_log,
   output logic [N-1:0]     sum_log,
   output lmd_pkg::lmd_rng_e rng
);
   import lmd_pkg::*;

   // two extra bits: one for the carry of a + b, one for the sign
   localparam int EW = N + 2;
   localparam logic [EW-1:0] ONE_W  = {{(EW-1){1'b0}}, 1'b1};
   localparam logic [EW-1:0] BIAS_I = (ONE_W << (INT_W - 1)) - ONE_W;
   localparam logic [EW-1:0] BIAS_C = BIAS_I << FRAC_W;

   logic [EW-1:0] a_w;
   logic [EW-1:0] b_w;
   logic [EW-1:0] raw;

   assign a_w = {2'b00, a_log};
   assign b_w = {2'b00, b_log};

   always_comb begin
      if (op == LMD_DIV) raw = a_w - b_w + BIAS_C;
      else               raw = a_w + b_w - BIAS_C;
   end

   assign sum_log = raw[N-1:0];

   always_comb begin
      if (raw[EW-1])          rng = LMD_RNG_LOW;
      else if (raw[EW-2])     rng = LMD_RNG_HIGH;
      else                    rng = LMD_RNG_IN;
   end

endmodule

// File: rtl/lmd_special.sv
// Zero, sign and divide-by-zero resolution, independent of the log codes.
module lmd_special (
   input  lmd_pkg::lmd_op_e op,
   input  logic             a_zero,
   input  logic             a_sign,
   input  logic             b_zero,
   input  logic             b_sign,
   output logic             res_sign,
   output logic             force_zero,
   output logic             force_max,
   output logic             div_by_zero
);
   import lmd_pkg::*;

   logic is_div;
   assign is_div = (op == LMD_DIV);

   assign res_sign = a_sign ^ b_sign;

   always_comb begin
      div_by_zero = 1'b0;
      force_zero  = 1'b0;
      force_max   = 1'b0;
      if (is_div) begin
         if (b_zero) begin
            div_by_zero = 1'b1;
            // 0/0 still reports a zero value; x/0 runs to the top code
            force_zero  = a_zero;
            force_max   = !a_zero;
         end else begin
            force_zero  = a_zero;
         end
      end else begin
         force_zero = a_zero | b_zero;
      end
   end

endmodule

// File: rtl/lmd_result_reg.sv
// Selects the final triple and flags, and holds them in the output register.
module lmd_result_reg #(
   parameter int N = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [N-1:0]      sum_log,
   input  lmd_pkg::lmd_rng_e rng,
   input  logic              res_sign,
   input  logic              force_zero,
   input  logic              force_max,
   input  logic              div_by_zero,
   output logic              valid_q,
   output logic              zero_q,
   output logic              sign_q,
   output logic [N-1:0]      log_q,
   output logic              ovf_q,
   output logic              unf_q,
   output logic              dbz_q
);
   import lmd_pkg::*;

   localparam logic [N-1:0] MAX_CODE = {N{1'b1}};

   logic         zero_d;
   logic         sign_d;
   logic [N-1:0] log_d;
   logic         ovf_d;
   logic         unf_d;

   // precedence: special operands first, then the range of the sum
   always_comb begin
      zero_d = 1'b0;
      sign_d = res_sign;
      log_d  = sum_log;
      ovf_d  = 1'b0;
      unf_d  = 1'b0;
      if (force_zero) begin
         zero_d = 1'b1;
         sign_d = 1'b0;
         log_d  = '0;
      end else if (force_max) begin
         log_d  = MAX_CODE;
      end else if (rng == LMD_RNG_HIGH) begin
         log_d  = MAX_CODE;
         ovf_d  = 1'b1;
      end else if (rng == LMD_RNG_LOW) begin
         zero_d = 1'b1;
         sign_d = 1'b0;
         log_d  = '0;
         unf_d  = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         zero_q  <= 1'b0;
         sign_q  <= 1'b0;
         log_q   <= '0;
         ovf_q   <= 1'b0;
         unf_q   <= 1'b0;
         dbz_q   <= 1'b0;
      end else begin
         valid_q <= load;
         if (load) begin
            zero_q <= zero_d;
            sign_q <= sign_d;
            log_q  <= log_d;
            ovf_q  <= ovf_d;
            unf_q  <= unf_d;
            dbz_q  <= div_by_zero;
         end
      end
   end

endmodule

// File: rtl/lmd_muldiv.sv
// Log-domain multiply/divide, one cycle from valid_in to valid_out.
module lmd_muldiv #(
   parameter int INT_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    valid_in,
   input  logic                    op_div,
   input  logic                    a_zero,
   input  logic                    a_sign,
   input  logic [INT_W+FRAC_W-1:0] a_log,
   input  logic                    b_zero,
   input  logic                    b_sign,
   input  logic [INT_W+FRAC_W-1:0] b_log,
   output logic                    valid_out,
   output logic                    r_zero,
   output logic                    r_sign,
   output logic [INT_W+FRAC_W-1:0] r_log,
   output logic                    r_ovf,
   output logic                    r_unf,
   output logic                    r_dbz
);
   import lmd_pkg::*;

   localparam int N = INT_W + FRAC_W;

   generate
      if (INT_W < 2) begin : g_chk_int
         $error("lmd_muldiv: INT_W must be at least 2 for a nonzero bias");
      end
      if (FRAC_W < 0) begin : g_chk_frac
         $error("lmd_muldiv: FRAC_W must not be negative");
      end
      if (N > 60) begin : g_chk_total
         $error("lmd_muldiv: INT_W + FRAC_W is limited to 60 bits");
      end
   endgenerate

   lmd_op_e      op;
   logic [N-1:0] sum_log;
   lmd_rng_e     rng;
   logic         res_sign;
   logic         force_zero;
   logic         force_max;
   logic         div_by_zero;

   assign op = op_div ? LMD_DIV : LMD_MUL;

   lmd_log_adder #(
      .INT_W  (INT_W),
      .FRAC_W (FRAC_W)
   ) u_add (
      .op      (op),
      .a_log   (a_log),
      .b_log   (b_log),
      .sum_log (sum_log),
      .rng     (rng)
   );

   lmd_special u_spec (
      .op          (op),
      .a_zero      (a_zero),
      .a_sign      (a_sign),
      .b_zero      (b_zero),
      .b_sign      (b_sign),
      .res_sign    (res_sign),
      .force_zero  (force_zero),
      .force_max   (force_max),
      .div_by_zero (div_by_zero)
   );

   lmd_result_reg #(
      .N (N)
   ) u_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (valid_in),
      .sum_log     (sum_log),
      .rng         (rng),
      .res_sign    (res_sign),
      .force_zero  (force_zero),
      .force_max   (force_max),
      .div_by_zero (div_by_zero),
      .valid_q     (valid_out),
      .zero_q      (r_zero),
      .sign_q      (r_sign),
      .log_q       (r_log),
      .ovf_q       (r_ovf),
      .unf_q       (r_unf),
      .dbz_q       (r_dbz)
   );

endmodule

// File: rtl/lmd_muldiv_chk.sv
module lmd_muldiv_chk #(
   parameter int INT_W  = 8,
   parameter int FRAC_W = 23,
   localparam int N     = INT_W + FRAC_W
) (
   input logic         clk,
   input logic         rst_n,
   input logic         valid_in,
   input logic         op_div,
   input logic         a_zero,
   input logic         a_sign,
   input logic         b_zero,
   input logic         b_sign,
   input logic         valid_out,
   input logic         r_zero,
   input logic         r_sign,
   input logic [N-1:0] r_log,
   input logic         r_ovf,
   input logic         r_unf,
   input logic         r_dbz
);
   localparam logic [N-1:0] TOP = {N{1'b1}};

   a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in |=> valid_out);

   a_r9_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> !valid_out);

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> ($stable(r_log) && $stable(r_zero) && $stable(r_sign)
                     && $stable(r_ovf) && $stable(r_unf) && $stable(r_dbz)));

   a_r3_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && !a_zero && !b_zero) |=> (r_zero || (r_sign == $past(a_sign ^ b_sign))));

   a_r4_mul_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && !op_div && (a_zero || b_zero)) |=> (r_zero && !r_ovf && !r_unf && !r_dbz));

   a_r4_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_out && r_zero) |-> (!r_sign && r_log == '0));

   a_r6_dbz_set: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && op_div && b_zero) |=> (r_dbz && !r_ovf && !r_unf));

   a_r6_dbz_only_div0: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && !(op_div && b_zero)) |=> !r_dbz);

   a_r7_ovf_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_out && r_ovf) |-> (r_log == TOP && !r_zero && !r_unf));

   a_r8_unf_flushes: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_out && r_unf) |-> (r_zero && !r_ovf));

endmodule

bind lmd_muldiv lmd_muldiv_chk #(
   .INT_W  (INT_W),
   .FRAC_W (FRAC_W)
) u_chk (.*);

// File: tb/sim_lmd_muldiv.sv
`timescale 1ns/1ps
module sim_lmd_muldiv;
   localparam int IW = 8;
   localparam int FW = 23;
   localparam int N  = IW + FW;
   localparam longint BIASC = ((64'sd1 <<< (IW - 1)) - 1) <<< FW;
   localparam longint MAXC  = (64'sd1 <<< N) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         valid_in = 1'b0;
   logic         op_div = 1'b0;
   logic         a_zero = 1'b0, a_sign = 1'b0, b_zero = 1'b0, b_sign = 1'b0;
   logic [N-1:0] a_log = '0, b_log = '0;
   logic         valid_out, r_zero, r_sign, r_ovf, r_unf, r_dbz;
   logic [N-1:0] r_log;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lmd_muldiv #(.INT_W(IW), .FRAC_W(FW)) u0 (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op_div(op_div),
      .a_zero(a_zero), .a_sign(a_sign), .a_log(a_log),
      .b_zero(b_zero), .b_sign(b_sign), .b_log(b_log),
      .valid_out(valid_out), .r_zero(r_zero), .r_sign(r_sign), .r_log(r_log),
      .r_ovf(r_ovf), .r_unf(r_unf), .r_dbz(r_dbz));

   // result word: {zero, sign, log, ovf, unf, dbz}
   function automatic logic [N+4:0] model(input logic d, input logic az, input logic as_,
                                          input longint al, input logic bz, input logic bs,
                                          input longint bl, output string tag);
      logic   sg = as_ ^ bs;
      longint s;
      if (d && bz) begin
         tag = "R6";
         if (az) return {1'b1, 1'b0, N'(0), 3'b001};
         return {1'b0, sg, N'(MAXC), 3'b001};
      end
      if (az || bz) begin
         tag = d ? "R5" : "R4";
         return {1'b1, 1'b0, N'(0), 3'b000};
      end
      s = d ? (al - bl + BIASC) : (al + bl - BIASC);
      if (s > MAXC) begin
         tag = "R7";
         return {1'b0, sg, N'(MAXC), 3'b100};
      end
      if (s < 0) begin
         tag = "R8";
         return {1'b1, 1'b0, N'(0), 3'b010};
      end
      tag = d ? "R2,R3" : "R1,R3";
      return {1'b0, sg, N'(s), 3'b000};
   endfunction

   function automatic logic [N+4:0] got_word();
      return {r_zero, r_sign, r_log, r_ovf, r_unf, r_dbz};
   endfunction

   task automatic check(input string tag, input logic [N+4:0] act, input logic [N+4:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   logic [N+4:0] last_exp;

   task automatic run_op(input logic d, input logic az, input logic as_, input longint al,
                         input logic bz, input logic bs, input longint bl);
      string tag;
      logic [N+4:0] e;
      @(negedge clk);
      op_div = d; a_zero = az; a_sign = as_; a_log = N'(al);
      b_zero = bz; b_sign = bs; b_log = N'(bl);
      valid_in = 1'b1;
      e = model(d, az, as_, al, bz, bs, bl, tag);
      @(negedge clk);
      valid_in = 1'b0;
      check("R9 valid_out", {{(N+4){1'b0}}, valid_out}, {{(N+4){1'b0}}, 1'b1});
      check(tag, got_word(), e);
      last_exp = e;
   endtask

   // R9: with valid_in low the outputs keep the last result, even as inputs move
   task automatic idle_hold();
      @(negedge clk);
      a_log = ~a_log; b_log = ~b_log; a_zero = ~a_zero; op_div = ~op_div;
      @(negedge clk);
      check("R9 valid low", {{(N+4){1'b0}}, valid_out}, '0);
      check("R9 hold", got_word(), last_exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7315));
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 reset", {valid_out, got_word()}, '0);
      rst_n = 1'b1;

      // R1 / R7 at the top of the range
      run_op(1'b0, 1'b0, 1'b0, BIASC, 1'b0, 1'b1, MAXC);
      run_op(1'b0, 1'b0, 1'b1, BIASC + 1, 1'b0, 1'b0, MAXC);
      run_op(1'b0, 1'b0, 1'b1, MAXC, 1'b0, 1'b1, MAXC);
      // R1 / R8 at the bottom of the range
      run_op(1'b0, 1'b0, 1'b1, 0, 1'b0, 1'b0, BIASC);
      run_op(1'b0, 1'b0, 1'b1, 0, 1'b0, 1'b0, BIASC - 1);
      // R2 / R7 / R8 divide edges
      run_op(1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0, BIASC);
      run_op(1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0, BIASC + 1);
      run_op(1'b1, 1'b0, 1'b1, MAXC - BIASC, 1'b0, 1'b0, 0);
      run_op(1'b1, 1'b0, 1'b1, MAXC - BIASC + 1, 1'b0, 1'b1, 0);
      run_op(1'b1, 1'b0, 1'b0, MAXC, 1'b0, 1'b0, 0);
      // R4 / R5 / R6 zero operands
      run_op(1'b0, 1'b1, 1'b1, 12345, 1'b0, 1'b0, 999);
      run_op(1'b0, 1'b0, 1'b1, 12345, 1'b1, 1'b0, 999);
      run_op(1'b1, 1'b1, 1'b1, 5, 1'b0, 1'b0, 7);
      run_op(1'b1, 1'b0, 1'b1, 5, 1'b1, 1'b0, 7);
      run_op(1'b1, 1'b1, 1'b0, 5, 1'b1, 1'b1, 7);
      run_op(1'b0, 1'b1, 1'b0, 0, 1'b1, 1'b0, 0);
      idle_hold();

      for (int i = 0; i < 400; i++) begin
         logic   d  = 1'($urandom % 2);
         logic   az = ($urandom % 8) == 0;
         logic   bz = ($urandom % 8) == 0;
         longint al = longint'($urandom) & MAXC;
         longint bl = longint'($urandom) & MAXC;
         if ((i % 3) == 0) begin
            // aim the result near one end of the range
            longint delta = longint'($urandom % 5) - 2;
            if ($urandom % 2) bl = d ? (al + BIASC - MAXC + delta) : (MAXC + BIASC - al + delta);
            else              bl = d ? (al + BIASC + delta)        : (BIASC - al + delta);
            if (bl < 0)    bl = 0;
            if (bl > MAXC) bl = MAXC;
         end
         run_op(d, az, 1'($urandom % 2), al, bz, 1'($urandom % 2), bl);
         if ((i % 25) == 0) idle_hold();
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule